// File: doc/BRIEF.md
# DDR Burst-of-Two SRAM Controller

This block sits between a simple request interface and a synchronous SRAM whose data port moves two words per clock while its command and address run at single rate. Each accepted request becomes one memory command: an active-low load strobe, a read select, an address, and for writes two data beats with one active-low byte-write mask per beat. Every access, read or write, moves exactly two words. Nothing else exists: no single-word and no longer bursts.

The double-rate port is modelled as two single-rate vectors per direction, one for the rising-edge beat and one for the falling-edge beat. A write-enable flag stands in for the shared pad driver. Read beats come back a fixed `RD_LAT` cycles after the read command. They are joined into one double-width response word, and a one-cycle valid flag marks it. The controller keeps its write driver off while read data is on the shared port. It stalls a write with `req_ready` when the write's data would land next to returning read data.

Top module: `ddr2b_ctrl`

## Requirements
- R1: `mem_ld_n` is low in exactly the cycle after a cycle with `req_valid` and `req_ready` both high. In every other cycle it is high, whatever `req_write`, `req_addr` and the data inputs hold. At most one command is issued per cycle.
- R2: In a command cycle, `mem_rd` is 1 for a read and 0 for a write, and `mem_addr` equals the accepted `req_addr`.
- R3: In a write command cycle, `mem_wd_rise` carries `req_wdata[DW-1:0]`, `mem_wd_fall` carries `req_wdata[2*DW-1:DW]`, and `mem_wd_oe` is 1. In every other cycle `mem_wd_oe` is 0.
- R4: Each lane is `DW/LANES` bits wide. Bit i of `req_wbe` (i < LANES) enables lane i of the rising beat (bits i*LW upward). Bit LANES+i enables lane i of the falling beat. The memory masks are active low (`mem_bwn_* = ~enable`) in write command cycles and all ones in all other cycles.
- R5: For a read accepted in cycle n, the SRAM returns its beats in cycle n+1+RD_LAT. `rsp_valid` is high for one cycle in cycle n+RD_LAT+2, with `rsp_rdata = {falling beat, rising beat}`. At no other time is `rsp_valid` high.
- R6: `mem_wd_oe` is 0 in any cycle in which read beats are on the port, in the cycle before such a cycle, and in the cycle after it.
- R7: A read is always accepted (`req_ready` = 1 when `req_write` = 0). For a write, `req_ready` is 0 exactly when a read was accepted k cycles earlier with k in {RD_LAT-1, RD_LAT, RD_LAT+1} and k >= 1.
- R8: During and directly after reset, `mem_ld_n` = 1, `mem_wd_oe` = 0, all `mem_bwn_*` bits are 1, `rsp_valid` = 0 and `req_ready` = 1.
- R9: Requests that do not collide on the bus are accepted back to back, one per cycle, and complete in issue order, so a read returns the data of every earlier write to its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and SRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Burst address |
| req_wdata | input | 2*DW | Write pair, low half is the first beat |
| req_wbe | input | 2*LANES | Active-high lane enables, low half for the first beat |
| rsp_valid | output | 1 | Read response valid for one cycle |
| rsp_rdata | output | 2*DW | Joined read pair, low half is the first beat |
| mem_ld_n | output | 1 | Active-low command strobe |
| mem_rd | output | 1 | 1 = read command, 0 = write command |
| mem_addr | output | AW | Single-rate address |
| mem_bwn_rise | output | LANES | Active-low lane masks, first beat |
| mem_bwn_fall | output | LANES | Active-low lane masks, second beat |
| mem_wd_rise | output | DW | Write beat on the rising edge |
| mem_wd_fall | output | DW | Write beat on the falling edge |
| mem_wd_oe | output | 1 | Controller drives the data port |
| mem_rq_rise | input | DW | Read beat captured on the rising edge |
| mem_rq_fall | input | DW | Read beat captured on the falling edge |

## Verification
If the read-return shift register drops a bit or shifts it by one position, the port shows it within RD_LAT+2 cycles of the read. Either `rsp_valid` misses its cycle, or a response is joined from beats that were never on the port. The same stage drives the turnaround window, so a wrong stage also makes `req_ready` wrong for a write one to three cycles after the read. It can also raise `mem_wd_oe` beside returning read data. If the command register holds a wrong lane mapping or beat order, the SRAM model is corrupted in the write cycle. That shows at the pins at once, and again in the data of the next read of that address.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;

  // First read-shift stage whose read would meet a write accepted now.
  // The write drives the port one cycle after accept; the read beats arrive
  // RD_LAT cycles after their command; one spare cycle on each side.
  function automatic int turn_lo(input int rd_lat);
    return (rd_lat >= 2) ? rd_lat - 2 : 0;
  endfunction

  // Cycles between accept and the response valid flag.
  function automatic int rsp_delay(input int rd_lat);
    return rd_lat + 2;
  endfunction

endpackage

// File: rtl/ddr2b_cmd_issue.sv
module ddr2b_cmd_issue #(
  parameter int AW    = 6,
  parameter int DW    = 18,
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc,
  input  logic               wr,
  input  logic [AW-1:0]      addr,
  input  logic [2*DW-1:0]    wdata,
  input  logic [2*LANES-1:0] wbe,
  output logic               ld_n,
  output logic               rd,
  output logic [AW-1:0]      addr_o,
  output logic [LANES-1:0]   bwn_rise,
  output logic [LANES-1:0]   bwn_fall,
  output logic [DW-1:0]      wd_rise,
  output logic [DW-1:0]      wd_fall,
  output logic               wd_oe
);

  logic wcmd;
  assign wcmd = acc & wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_n     <= 1'b1;
      rd       <= 1'b1;
      addr_o   <= '0;
      bwn_rise <= '1;
      bwn_fall <= '1;
      wd_rise  <= '0;
      wd_fall  <= '0;
      wd_oe    <= 1'b0;
    end else begin
      ld_n  <= ~acc;
      rd    <= acc ? ~wr : 1'b1;
      wd_oe <= wcmd;
      if (acc) addr_o <= addr;
      if (wcmd) begin
        bwn_rise <= ~wbe[LANES-1:0];
        bwn_fall <= ~wbe[2*LANES-1:LANES];
        wd_rise  <= wdata[DW-1:0];
        wd_fall  <= wdata[2*DW-1:DW];
      end else begin
        bwn_rise <= '1;
        bwn_fall <= '1;
      end
    end
  end

endmodule

// File: rtl/ddr2b_rd_track.sv
module ddr2b_rd_track #(
  parameter int DW     = 18,
  parameter int RD_LAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_issue,
  input  logic [DW-1:0]   q_rise,
  input  logic [DW-1:0]   q_fall,
  output logic            wr_block,
  output logic            rd_due,
  output logic            rsp_valid,
  output logic [2*DW-1:0] rsp_rdata
);

  localparam int LO = ddr2b_pkg::turn_lo(RD_LAT);

  // Stage k is high k cycles after a read command was on the pins.
  logic [RD_LAT:0] rd_sh;
  logic [RD_LAT:0] win;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_sh <= '0;
    else        rd_sh <= {rd_sh[RD_LAT-1:0], rd_issue};
  end

  for (genvar k = 0; k <= RD_LAT; k++) begin : g_win
    if (k >= LO) begin : g_on
      assign win[k] = rd_sh[k];
    end else begin : g_off
      assign win[k] = 1'b0;
    end
  end

  assign wr_block = |win;
  assign rd_due   = rd_sh[RD_LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_due;
      if (rd_due) rsp_rdata <= {q_fall, q_rise};
    end
  end

endmodule

// File: rtl/ddr2b_ctrl.sv
module ddr2b_ctrl #(
  parameter int AW     = 6,
  parameter int DW     = 18,
  parameter int LANES  = 2,
  parameter int RD_LAT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [2*DW-1:0]    req_wdata,
  input  logic [2*LANES-1:0] req_wbe,
  output logic               rsp_valid,
  output logic [2*DW-1:0]    rsp_rdata,
  output logic               mem_ld_n,
  output logic               mem_rd,
  output logic [AW-1:0]      mem_addr,
  output logic [LANES-1:0]   mem_bwn_rise,
  output logic [LANES-1:0]   mem_bwn_fall,
  output logic [DW-1:0]      mem_wd_rise,
  output logic [DW-1:0]      mem_wd_fall,
  output logic               mem_wd_oe,
  input  logic [DW-1:0]      mem_rq_rise,
  input  logic [DW-1:0]      mem_rq_fall
);

  // Named events for the checker.
  logic acc_w;
  logic rd_issue_w;
  logic wr_block_w;
  logic rd_due_w;

  assign req_ready  = ~(req_write & wr_block_w);
  assign acc_w      = req_valid & req_ready;
  assign rd_issue_w = acc_w & ~req_write;

  ddr2b_cmd_issue #(.AW(AW), .DW(DW), .LANES(LANES)) cmd_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc_w),
    .wr       (req_write),
    .addr     (req_addr),
    .wdata    (req_wdata),
    .wbe      (req_wbe),
    .ld_n     (mem_ld_n),
    .rd       (mem_rd),
    .addr_o   (mem_addr),
    .bwn_rise (mem_bwn_rise),
    .bwn_fall (mem_bwn_fall),
    .wd_rise  (mem_wd_rise),
    .wd_fall  (mem_wd_fall),
    .wd_oe    (mem_wd_oe)
  );

  ddr2b_rd_track #(.DW(DW), .RD_LAT(RD_LAT)) trk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_issue  (rd_issue_w),
    .q_rise    (mem_rq_rise),
    .q_fall    (mem_rq_fall),
    .wr_block  (wr_block_w),
    .rd_due    (rd_due_w),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/ddr2b_ctrl_chk.sv
module ddr2b_ctrl_chk #(
  parameter int AW     = 6,
  parameter int DW     = 18,
  parameter int LANES  = 2,
  parameter int RD_LAT = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [AW-1:0]      req_addr,
  input logic               rsp_valid,
  input logic [2*DW-1:0]    rsp_rdata,
  input logic               mem_ld_n,
  input logic               mem_rd,
  input logic [AW-1:0]      mem_addr,
  input logic [LANES-1:0]   mem_bwn_rise,
  input logic [LANES-1:0]   mem_bwn_fall,
  input logic               mem_wd_oe,
  input logic [DW-1:0]      mem_rq_rise,
  input logic [DW-1:0]      mem_rq_fall,
  input logic               rd_due_w
);

  a_r1_idle_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> mem_ld_n);

  a_r2_cmd_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (!mem_ld_n && mem_rd == !$past(req_write) && mem_addr == $past(req_addr)));

  a_r3_drive_only_writes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wd_oe |-> (!mem_ld_n && !mem_rd));

  a_r4_masks_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ld_n || mem_rd) |-> (&mem_bwn_rise && &mem_bwn_fall));

  a_r5_rsp_from_port: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(rd_due_w) && rsp_rdata == $past({mem_rq_fall, mem_rq_rise})));

  a_r6_no_drive_on_return: assert property (@(posedge clk) disable iff (!rst_n)
    rd_due_w |-> !mem_wd_oe);

  a_r6_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wd_oe |=> !rd_due_w);

  a_r6_gap_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_due_w |=> !mem_wd_oe);

  a_r7_reads_never_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !req_write |-> req_ready);

endmodule

bind ddr2b_ctrl ddr2b_ctrl_chk #(.AW(AW), .DW(DW), .LANES(LANES), .RD_LAT(RD_LAT)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .rsp_valid    (rsp_valid),
  .rsp_rdata    (rsp_rdata),
  .mem_ld_n     (mem_ld_n),
  .mem_rd       (mem_rd),
  .mem_addr     (mem_addr),
  .mem_bwn_rise (mem_bwn_rise),
  .mem_bwn_fall (mem_bwn_fall),
  .mem_wd_oe    (mem_wd_oe),
  .mem_rq_rise  (mem_rq_rise),
  .mem_rq_fall  (mem_rq_fall),
  .rd_due_w     (rd_due_w)
);

// File: tb/ddr2b_ctrl_tb_top.sv
module ddr2b_ctrl_tb_top;
  localparam int AW = 6, DW = 18, LANES = 2, RD_LAT = 2;
  localparam int LW = DW / LANES, WW = 2 * DW, DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [WW-1:0] req_wdata = '0;
  logic [2*LANES-1:0] req_wbe = '0;
  logic req_ready, rsp_valid, mem_ld_n, mem_rd, mem_wd_oe;
  logic [WW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic [LANES-1:0] mem_bwn_rise, mem_bwn_fall;
  logic [DW-1:0] mem_wd_rise, mem_wd_fall, mem_rq_rise, mem_rq_fall;

  ddr2b_ctrl #(.AW(AW), .DW(DW), .LANES(LANES), .RD_LAT(RD_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wbe(req_wbe), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ld_n(mem_ld_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_bwn_rise(mem_bwn_rise), .mem_bwn_fall(mem_bwn_fall),
    .mem_wd_rise(mem_wd_rise), .mem_wd_fall(mem_wd_fall), .mem_wd_oe(mem_wd_oe),
    .mem_rq_rise(mem_rq_rise), .mem_rq_fall(mem_rq_fall));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit started = 0;

  function automatic logic [WW-1:0] init_word(input int i);
    return {DW'(i * 977 + 3), DW'((i * 131) ^ 18'h2AAAA)};
  endfunction

  // SRAM model driven only from the memory pins.
  logic [WW-1:0] sram [DEPTH];
  logic [RD_LAT-1:0] pv = '0;
  logic [WW-1:0] pd [RD_LAT];
  always @(posedge clk) begin
    pv[0] <= !mem_ld_n && mem_rd;
    pd[0] <= sram[mem_addr];
    for (int k = 1; k < RD_LAT; k++) begin
      pv[k] <= pv[k-1];
      pd[k] <= pd[k-1];
    end
    if (!mem_ld_n && !mem_rd)
      for (int i = 0; i < LANES; i++) begin
        if (!mem_bwn_rise[i]) sram[mem_addr][i*LW +: LW] <= mem_wd_rise[i*LW +: LW];
        if (!mem_bwn_fall[i]) sram[mem_addr][DW + i*LW +: LW] <= mem_wd_fall[i*LW +: LW];
      end
  end
  assign mem_rq_rise = pd[RD_LAT-1][DW-1:0];
  assign mem_rq_fall = pd[RD_LAT-1][WW-1:DW];

  // Scoreboard state computed from the requirements.
  logic [WW-1:0] shadow [DEPTH];
  bit rd_acc[int];
  bit acc_at[int];
  bit exp_rd_at[int];
  logic [AW-1:0] exp_addr_at[int];
  logic [WW-1:0] exp_wd_at[int];
  logic [2*LANES-1:0] exp_wbe_at[int];
  typedef struct { logic [WW-1:0] d; int due; } rsp_t;
  rsp_t sb[$];

  task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [WW-1:0] d,
                       input logic [2*LANES-1:0] be);
    bit got = 0;
    bit exp_rdy;
    while (!got) begin
      @(negedge clk);
      req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_wbe = be;
      #1;
      exp_rdy = 1;
      if (w)
        for (int k = 1; k <= RD_LAT + 1; k++)
          if (k >= RD_LAT - 1 && rd_acc.exists(cyc - k)) exp_rdy = 0;
      chk(req_ready == exp_rdy, "R7 ready", WW'(req_ready), WW'(exp_rdy));
      if (req_ready) begin
        got = 1;
        acc_at[cyc] = 1; exp_rd_at[cyc] = !w; exp_addr_at[cyc] = a;
        if (w) begin
          exp_wd_at[cyc] = d; exp_wbe_at[cyc] = be;
          for (int i = 0; i < LANES; i++) begin
            if (be[i]) shadow[a][i*LW +: LW] = d[i*LW +: LW];
            if (be[LANES+i]) shadow[a][DW + i*LW +: LW] = d[DW + i*LW +: LW];
          end
        end else begin
          rd_acc[cyc] = 1;
          sb.push_back('{shadow[a], cyc + RD_LAT + 2});
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0; req_write = 1'($urandom); req_addr = AW'($urandom);
      req_wdata = {$urandom, $urandom}; req_wbe = '1;
    end
  endtask

  // Monitor: command pins, turnaround and responses.
  bit qv_prev = 0, oe_prev = 0;
  always @(negedge clk) if (started) begin
    automatic int n = cyc;
    automatic bit a = acc_at.exists(n - 1);
    automatic bit wc = a && !exp_rd_at[n-1];
    automatic bit qv = pv[RD_LAT-1];
    chk(mem_ld_n == !a, "R1 ld_n", WW'(mem_ld_n), WW'(!a));
    if (a) begin
      chk(mem_rd == exp_rd_at[n-1], "R2 rd", WW'(mem_rd), WW'(exp_rd_at[n-1]));
      chk(mem_addr == exp_addr_at[n-1], "R2 addr", WW'(mem_addr), WW'(exp_addr_at[n-1]));
    end
    chk(mem_wd_oe == wc, "R3 oe", WW'(mem_wd_oe), WW'(wc));
    if (wc) begin
      chk({mem_wd_fall, mem_wd_rise} == exp_wd_at[n-1], "R3 data",
          {mem_wd_fall, mem_wd_rise}, exp_wd_at[n-1]);
      chk({mem_bwn_fall, mem_bwn_rise} == ~exp_wbe_at[n-1], "R4 masks",
          WW'({mem_bwn_fall, mem_bwn_rise}), WW'(~exp_wbe_at[n-1]));
    end else
      chk(&{mem_bwn_fall, mem_bwn_rise}, "R4 masks idle",
          WW'({mem_bwn_fall, mem_bwn_rise}), WW'({2*LANES{1'b1}}));
    if (mem_wd_oe || qv)
      chk(!(mem_wd_oe && (qv || qv_prev)) && !(qv && oe_prev), "R6 turnaround",
          WW'({mem_wd_oe, qv, qv_prev, oe_prev}), '0);
    qv_prev = qv; oe_prev = mem_wd_oe;
    if (sb.size() > 0 && sb[0].due == n) begin
      chk(rsp_valid == 1, "R5 valid", WW'(rsp_valid), 1);
      chk(rsp_rdata == sb[0].d, "R5/R9 data", rsp_rdata, sb[0].d);
      void'(sb.pop_front());
    end else
      chk(rsp_valid == 0, "R5 spurious", WW'(rsp_valid), 0);
  end

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog cycle %0d actual=hung expected=done", cyc);
    summary();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      sram[i] = init_word(i); shadow[i] = init_word(i);
    end
    for (int k = 0; k < RD_LAT; k++) pd[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    req_write = 1;
    #1;
    // R8 reset state
    chk(mem_ld_n == 1, "R8 ld_n", WW'(mem_ld_n), 1);
    chk(mem_wd_oe == 0, "R8 oe", WW'(mem_wd_oe), 0);
    chk(&{mem_bwn_fall, mem_bwn_rise}, "R8 masks", WW'({mem_bwn_fall, mem_bwn_rise}), WW'({2*LANES{1'b1}}));
    chk(rsp_valid == 0, "R8 rsp", WW'(rsp_valid), 0);
    rst_n = 1;
    started = 1;
    #1 chk(req_ready == 1, "R8 ready", WW'(req_ready), 1);

    idle(5);                                   // R1: garbage while not valid
    for (int i = 0; i < 8; i++) issue(1, AW'(i), {DW'(i * 7 + 1), DW'(i * 11 + 2)}, '1);
    for (int i = 0; i < 8; i++) issue(0, AW'(i), '0, '0);       // R9 back to back
    idle(2);
    issue(1, 3, {WW{1'b0}}, 4'b0101);          // R4 lane 0 of both beats
    issue(1, 4, {WW{1'b1}}, 4'b1000);          // R4 lane 1 of second beat only
    issue(1, 5, {WW{1'b1}}, 4'b0000);          // R4 no lanes
    issue(0, 3, '0, '0);
    issue(0, 4, '0, '0);
    issue(0, 5, '0, '0);
    for (int g = 0; g <= 4; g++) begin         // R7 read then write at each gap
      issue(0, AW'(g + 10), '0, '0);
      idle(g);
      issue(1, AW'(g + 10), {WW{1'b1}} ^ WW'(g), '1);
      issue(0, AW'(g + 10), '0, '0);
    end
    idle(RD_LAT + 4);
    for (int i = 0; i < 400; i++) begin
      issue(1'($urandom), AW'($urandom), {$urandom, $urandom}, 4'($urandom));
      if ($urandom % 3 == 0) idle($urandom % 3);
    end
    idle(RD_LAT + 6);
    chk(sb.size() == 0, "R5 drained", WW'(sb.size()), 0);
    summary();
  end

endmodule